// File: doc/BRIEF.md
# Power-Fail-Gated SRAM Bank Selector

This block sits between a byte-wide asynchronous-style bus and two external static RAM banks plus a small internal register file. From an external enable and a bank-select line it chooses which RAM bank's active-low enable to pull low. From a register-side chip enable, output enable and write enable it produces gated read and write strobes for a 16-entry register file, and it controls the output enable of the shared data bus.

A supply monitor outside the block reports the power state as a two-bit code: 0 means supply valid, 1 means below the deselect threshold, 2 means battery backup, and 3 is reserved and handled as a failure. The code is resynchronised into the block's clock domain. While the synchronised state is anything but valid, both RAM enables stay high, no register access gets through, and the data bus is not driven. This keeps the external memory and the register contents intact through supply transients.

A register write is collected while the bus holds chip enable and write enable low. It is committed as a one-cycle strobe after the write phase ends. A write that is open when power fails is dropped.

Top module: `bank_sel_gate`

## Requirements
- R1: With supply valid, `ext_en_n` low and `bank_sel` 0, `ram_en_n[0]` is low and `ram_en_n[1]` is high. At no time are both RAM enables low.
- R2: With supply valid, `ext_en_n` low and `bank_sel` 1, `ram_en_n[0]` is high and `ram_en_n[1]` is low.
- R3: With `ext_en_n` high, both RAM enables are high whatever `bank_sel` is.
- R4: When the synchronised power code is non-zero (1, 2 or 3), both RAM enables are high whatever the bus inputs are.
- R5: With `bus_ce_n` high, `bus_dout_en` is low and no register strobe is issued.
- R6: `bus_ce_n` low with `bus_we_n` low is a write, whatever `bus_oe_n` is. During the write `bus_dout_en` stays low. The address and data seen at the last clock edge of the write phase appear on `rf_wr_addr`/`rf_wdata` with `rf_wr` high for exactly one cycle, in the cycle after the first edge at which the write phase is seen ended.
- R7: `bus_ce_n` low, `bus_oe_n` low and `bus_we_n` high is a read. `rf_rd` is high, `rf_rd_addr` equals `bus_addr`, `bus_dout_en` is high and `bus_dout` equals `rf_rdata`.
- R8: `bus_ce_n` low with both `bus_oe_n` and `bus_we_n` high leaves `bus_dout_en` low.
- R9: While supply is not valid, reads and writes are ignored. `bus_dout_en`, `rf_rd` and `rf_wr` stay low, and `rf_rd_addr`, `rf_wr_addr` and `rf_wdata` are zero. A write made during a failure produces no strobe after supply returns.
- R10: A change of `pwr_mode` reaches the outputs after exactly two rising clock edges. The synchroniser resets to the failed state, so after reset release supply counts as valid only from the second edge on.
- R11: A write that is open when the synchronised supply fails is aborted. No strobe is issued for it, including after supply recovers and the write phase ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | 2 | Raw power code from the supply monitor (0 valid, 1 low, 2 backup, 3 reserved) |
| ext_en_n | input | 1 | External RAM enable, active low |
| bank_sel | input | 1 | RAM bank select (0 first bank, 1 second bank) |
| ram_en_n | output | 2 | Active-low RAM bank enables, bit 0 first bank |
| bus_ce_n | input | 1 | Register chip enable, active low |
| bus_oe_n | input | 1 | Register output enable, active low |
| bus_we_n | input | 1 | Register write enable, active low |
| bus_addr | input | 4 | Register address |
| bus_din | input | 8 | Write data from the bus |
| bus_dout | output | 8 | Read data toward the bus, zero when not driven |
| bus_dout_en | output | 1 | Data bus output enable |
| rf_rdata | input | 8 | Read data from the register file |
| rf_rd | output | 1 | Register read enable |
| rf_rd_addr | output | 4 | Register read address |
| rf_wr | output | 1 | One-cycle register write strobe |
| rf_wr_addr | output | 4 | Register write address |
| rf_wdata | output | 8 | Register write data |

## Verification
The assertions assume that the bus strobes and select lines are stable around each rising clock edge. They also assume that a write phase lasts at least one sampled edge, so that a single strobe per write is meaningful. The raw power code may change at any time, but the checks only reason about its synchronised value. The stimulus changes every input only at falling clock edges, holds each write for at least one rising edge, and moves the power code through valid, low and backup both while the bus is idle and while a write is open.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

  typedef enum logic [1:0] {
    PWR_VALID  = 2'd0,
    PWR_LOW    = 2'd1,
    PWR_BACKUP = 2'd2,
    PWR_RSVD   = 2'd3
  } pwr_code_e;

  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_OPEN  = 2'd1,
    WR_ABORT = 2'd2
  } wr_state_e;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync
  import bank_sel_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_raw,
  output logic       supply_ok
);

  logic [1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= PWR_BACKUP;
          else        stage_q[g] <= mode_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= PWR_BACKUP;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  // Any code other than valid, including the reserved one, counts as failure.
  assign supply_ok = (stage_q[STAGES-1] == PWR_VALID);

endmodule

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int NUM_BANKS = 2,
  parameter int SEL_W     = 1
) (
  input  logic                 supply_ok,
  input  logic                 ext_en_n,
  input  logic [SEL_W-1:0]     bank_sel,
  output logic [NUM_BANKS-1:0] ram_en_n
);

  logic access_ok;
  assign access_ok = supply_ok && !ext_en_n;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign ram_en_n[b] = !(access_ok && (bank_sel == SEL_W'(b)));
    end
  endgenerate

endmodule

// File: rtl/reg_port.sv
module reg_port
  import bank_sel_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              rd,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wdata
);

  logic              wr_req;
  logic              rd_req;
  wr_state_e         state_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_data_q;
  logic              pulse_q;

  assign wr_req = !ce_n && !we_n;
  assign rd_req = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WR_IDLE;
      lat_addr_q <= '0;
      lat_data_q <= '0;
      pulse_q    <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      unique case (state_q)
        WR_IDLE: begin
          if (wr_req && supply_ok) begin
            state_q    <= WR_OPEN;
            lat_addr_q <= addr;
            lat_data_q <= din;
          end else if (wr_req) begin
            state_q <= WR_ABORT;
          end
        end
        WR_OPEN: begin
          if (!supply_ok) begin
            state_q <= WR_ABORT;
          end else if (wr_req) begin
            lat_addr_q <= addr;
            lat_data_q <= din;
          end else begin
            state_q <= WR_IDLE;
            pulse_q <= 1'b1;
          end
        end
        WR_ABORT: begin
          if (!wr_req) state_q <= WR_IDLE;
        end
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  assign wr      = pulse_q && supply_ok;
  assign wr_addr = wr ? lat_addr_q : '0;
  assign wdata   = wr ? lat_data_q : '0;

  assign rd      = rd_req && supply_ok;
  assign rd_addr = rd ? addr : '0;
  assign dout_en = rd;
  assign dout    = rd ? rdata : '0;

endmodule

// File: rtl/bank_sel_gate.sv
module bank_sel_gate
  import bank_sel_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int NUM_BANKS   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pwr_mode,
  input  logic                 ext_en_n,
  input  logic [SEL_W-1:0]     bank_sel,
  output logic [NUM_BANKS-1:0] ram_en_n,
  input  logic                 bus_ce_n,
  input  logic                 bus_oe_n,
  input  logic                 bus_we_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_din,
  output logic [DATA_W-1:0]    bus_dout,
  output logic                 bus_dout_en,
  input  logic [DATA_W-1:0]    rf_rdata,
  output logic                 rf_rd,
  output logic [ADDR_W-1:0]    rf_rd_addr,
  output logic                 rf_wr,
  output logic [ADDR_W-1:0]    rf_wr_addr,
  output logic [DATA_W-1:0]    rf_wdata
);

  logic supply_ok;

  pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_raw  (pwr_mode),
    .supply_ok (supply_ok)
  );

  bank_decode #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_decode (
    .supply_ok (supply_ok),
    .ext_en_n  (ext_en_n),
    .bank_sel  (bank_sel),
    .ram_en_n  (ram_en_n)
  );

  reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .ce_n      (bus_ce_n),
    .oe_n      (bus_oe_n),
    .we_n      (bus_we_n),
    .addr      (bus_addr),
    .din       (bus_din),
    .rdata     (rf_rdata),
    .dout      (bus_dout),
    .dout_en   (bus_dout_en),
    .rd        (rf_rd),
    .rd_addr   (rf_rd_addr),
    .wr        (rf_wr),
    .wr_addr   (rf_wr_addr),
    .wdata     (rf_wdata)
  );

endmodule

// File: rtl/bank_sel_chk.sv
module bank_sel_chk #(
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 supply_ok,
  input logic                 ext_en_n,
  input logic [NUM_BANKS-1:0] ram_en_n,
  input logic                 bus_ce_n,
  input logic                 bus_we_n,
  input logic                 bus_dout_en,
  input logic                 rf_rd,
  input logic                 rf_wr
);

  assert_bank_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ram_en_n) <= 1);

  assert_ext_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en_n |-> (&ram_en_n));

  assert_pfail_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (&ram_en_n));

  assert_deselect_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce_n |-> !bus_dout_en);

  assert_write_nodrive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce_n && !bus_we_n) |-> !bus_dout_en);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> !rf_wr);

  assert_pfail_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (!bus_dout_en && !rf_rd && !rf_wr));

  assert_strobe_after_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> $past(supply_ok));

endmodule

bind bank_sel_gate bank_sel_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok   (supply_ok),
  .ext_en_n    (ext_en_n),
  .ram_en_n    (ram_en_n),
  .bus_ce_n    (bus_ce_n),
  .bus_we_n    (bus_we_n),
  .bus_dout_en (bus_dout_en),
  .rf_rd       (rf_rd),
  .rf_wr       (rf_wr)
);

// File: tb/tb_bank_sel_gate.sv
`timescale 1ns/100ps
module tb_bank_sel_gate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwr_mode = 2'd0;
  logic       ext_en_n = 1'b0;
  logic [0:0] bank_sel = 1'b0;
  logic [1:0] ram_en_n;
  logic       bus_ce_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_dout_en;
  logic [7:0] rf_rdata = '0;
  logic       rf_rd;
  logic [3:0] rf_rd_addr;
  logic       rf_wr;
  logic [3:0] rf_wr_addr;
  logic [7:0] rf_wdata;

  always #2.5 clk = ~clk;

  bank_sel_gate dut (
    .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .ext_en_n(ext_en_n),
    .bank_sel(bank_sel), .ram_en_n(ram_en_n), .bus_ce_n(bus_ce_n),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .rf_rdata(rf_rdata), .rf_rd(rf_rd), .rf_rd_addr(rf_rd_addr),
    .rf_wr(rf_wr), .rf_wr_addr(rf_wr_addr), .rf_wdata(rf_wdata)
  );

  typedef struct {
    string      tag;
    logic [1:0] ram;
    logic       oe;
    logic [7:0] dq;
    logic       rd;
    logic [3:0] ra;
    logic       wr;
    logic [3:0] wa;
    logic [7:0] wd;
  } exp_t;

  exp_t exp_q[$];
  int   applied = 0;
  int   errors  = 0;
  bit   done    = 0;

  task automatic ap(input logic [1:0] m, input logic x, input logic b,
                    input logic c, input logic o, input logic w,
                    input logic [3:0] a, input logic [7:0] d, input logic [7:0] r);
    @(negedge clk);
    pwr_mode = m; ext_en_n = x; bank_sel = b;
    bus_ce_n = c; bus_oe_n = o; bus_we_n = w;
    bus_addr = a; bus_din = d; rf_rdata = r;
  endtask

  // Expected read strobe mirrors the output enable (R7); read address is the bus address then.
  task automatic ex(input string tag, input logic [1:0] ram, input logic oe,
                    input logic [7:0] dq, input logic wr, input logic [3:0] wa,
                    input logic [7:0] wd);
    exp_t e;
    e.tag = tag; e.ram = ram; e.oe = oe; e.dq = dq;
    e.rd = oe; e.ra = oe ? bus_addr : 4'h0;
    e.wr = wr; e.wa = wa; e.wd = wd;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      applied++;
      if (ram_en_n !== e.ram || bus_dout_en !== e.oe || bus_dout !== e.dq ||
          rf_rd !== e.rd || rf_rd_addr !== e.ra || rf_wr !== e.wr ||
          rf_wr_addr !== e.wa || rf_wdata !== e.wd) begin
        errors++;
        $display("FAIL %s: got ram=%b oe=%b dq=%h rd=%b ra=%h wr=%b wa=%h wd=%h exp ram=%b oe=%b dq=%h rd=%b ra=%h wr=%b wa=%h wd=%h",
                 e.tag, ram_en_n, bus_dout_en, bus_dout, rf_rd, rf_rd_addr, rf_wr,
                 rf_wr_addr, rf_wdata, e.ram, e.oe, e.dq, e.rd, e.ra, e.wr, e.wa, e.wd);
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    // Reset release and synchroniser latency (R10)
    ap(0,0,0, 1,1,1, 0,0,0); rst_n = 1'b1; ex("R10 reset", 2'b11, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R10 one edge", 2'b11, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R1 bank0",  2'b10, 0, 0, 0, 0, 0);
    ap(0,0,1, 1,1,1, 0,0,0); ex("R2 bank1",  2'b01, 0, 0, 0, 0, 0);
    ap(0,1,0, 1,1,1, 0,0,0); ex("R3 ext sel0", 2'b11, 0, 0, 0, 0, 0);
    ap(0,1,1, 1,1,1, 0,0,0); ex("R3 ext sel1", 2'b11, 0, 0, 0, 0, 0);
    // Register bus
    ap(0,0,0, 1,0,1, 3,0,8'h5A); ex("R5 ce high", 2'b10, 0, 0, 0, 0, 0);
    ap(0,0,0, 0,0,1, 3,0,8'h5A); ex("R7 read", 2'b10, 1, 8'h5A, 0, 0, 0);
    ap(0,0,0, 0,1,1, 3,0,8'h5A); ex("R8 no oe", 2'b10, 0, 0, 0, 0, 0);
    ap(0,0,0, 0,0,0, 9,8'hC3,8'h5A); ex("R6 write oe low", 2'b10, 0, 0, 0, 0, 0);
    ap(0,0,0, 0,1,0, 9,8'h3C,8'h5A); ex("R6 write held", 2'b10, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R6 phase end", 2'b10, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R6 strobe", 2'b10, 0, 0, 1, 4'h9, 8'h3C);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R6 single", 2'b10, 0, 0, 0, 0, 0);
    // Power fail during a read
    ap(1,0,0, 0,0,1, 3,0,8'h5A); ex("R10 fail lag0", 2'b10, 1, 8'h5A, 0, 0, 0);
    ap(1,0,0, 0,0,1, 3,0,8'h5A); ex("R10 fail lag1", 2'b10, 1, 8'h5A, 0, 0, 0);
    ap(1,0,0, 0,0,1, 3,0,8'h5A); ex("R9 read blocked", 2'b11, 0, 0, 0, 0, 0);
    ap(2,0,1, 0,0,1, 3,0,8'h5A); ex("R4 backup", 2'b11, 0, 0, 0, 0, 0);
    ap(2,0,1, 0,1,0, 4,8'h11,0); ex("R9 write blocked", 2'b11, 0, 0, 0, 0, 0);
    ap(2,0,1, 1,1,1, 0,0,0); ex("R9 no strobe", 2'b11, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R10 recover lag0", 2'b11, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R10 recover lag1", 2'b11, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R9 recovered", 2'b10, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R9 no late strobe", 2'b10, 0, 0, 0, 0, 0);
    // Write aborted by power fail
    ap(0,0,0, 0,1,0, 5,8'h77,0); ex("R11 open", 2'b10, 0, 0, 0, 0, 0);
    ap(2,0,0, 0,1,0, 5,8'h77,0); ex("R11 lag0", 2'b10, 0, 0, 0, 0, 0);
    ap(2,0,0, 0,1,0, 5,8'h77,0); ex("R11 lag1", 2'b10, 0, 0, 0, 0, 0);
    ap(2,0,0, 0,1,0, 5,8'h77,0); ex("R4 fail in write", 2'b11, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R11 release", 2'b11, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R11 wait", 2'b11, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R11 no strobe", 2'b10, 0, 0, 0, 0, 0);
    ap(0,0,0, 1,1,1, 0,0,0); ex("R11 still none", 2'b10, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

endmodule